// File: doc/BRIEF.md
# PI Phase-Lock Loop Filter

This block is the arithmetic core of a digital phase-locked loop that keeps a local sample clock aligned with a remote phase reference. On each update strobe it takes a signed phase error and subtracts a measured channel-asymmetry correction from it. It can also take a frequency-deviation measurement, which is used only when its valid flag is set. A proportional path and one shared, saturating integrator turn these inputs into a registered frequency-correction word.

The correction word steers a counter-based sample clock. On every clock the counter advances its phase by a nominal step plus the correction, so the counter is the loop's second integration stage. It pulses a tick each time its phase wraps.

Gains are compile-time fixed-point constants. For a critically damped response, choose them from the update interval Tu, the phase time constant Tp and the frequency time constant Tf, all in seconds:
- proportional gain: 2 / Tp
- integral gain: Tu / Tp²
- frequency gain: Tu / Tf

Top module: `pll_loop_filter`

## Requirements
- R1: While `rst_ni` is low, `freq_o`, `sat_o`, `phase_o` and `tick_o` are all zero.
- R2: The filter works on the error e = `phase_i` − `asym_i`, computed at one bit wider than the input. Equal phase and asymmetry inputs add nothing to the integrator.
- R3: On a clock edge with `upd_i` high, the accumulator adds round(KI·e) + round(KF·d), where d is `fdev_i`. The phase term and the frequency term go into this single accumulator.
- R4: When `fdev_vld_i` is low, d is taken as zero and `fdev_i` has no effect on the outputs.
- R5: The accumulator clamps to the range from −2^(W_ACC−1) to 2^(W_ACC−1)−1 instead of wrapping. `sat_o` is 1 after an update whose sum was clamped, and 0 after an update that was not clamped. Between updates `sat_o` holds its value.
- R6: At the edge that samples `upd_i` high, `freq_o` is loaded with round(KP·e) plus the new accumulator value, clamped to the W_ACC range. The new value is visible from the next cycle.
- R7: Each product with a gain has FRAC fraction bits and is rounded half up, using floor((x + 2^(FRAC−1)) / 2^FRAC).
- R8: On every clock, `phase_o` advances modulo 2^CNT_W by a step equal to NOM_INC + `freq_o`. The step is clamped to the range 0 to 2^CNT_W−1, so the counter never runs backward.
- R9: `tick_o` is 1 for exactly the cycle that follows an advance in which the phase wrapped past 2^CNT_W.
- R10: On a clock edge with `upd_i` low, the accumulator, `freq_o` and `sat_o` keep their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| upd_i | input | 1 | Filter update strobe |
| phase_i | input | W_PH | Raw phase difference, signed |
| asym_i | input | W_PH | Channel asymmetry correction, signed |
| fdev_i | input | W_FD | Frequency deviation measurement, signed |
| fdev_vld_i | input | 1 | Frequency deviation is valid |
| freq_o | output | W_ACC | Frequency correction word, signed |
| sat_o | output | 1 | Last update clamped the accumulator |
| phase_o | output | CNT_W | Sample-clock phase |
| tick_o | output | 1 | Sample tick on phase wrap |

## Verification
The bench builds the block with a 12-bit accumulator, 4 fraction bits, 8-bit gains of 2.0, 0.5 and 1.0, and a 10-bit sample counter with a nominal step of 100. With these narrow widths, a handful of full-scale errors drives the accumulator into both clamps, and the half-up rounding of ±0.5 products shows up on single-unit errors. Large corrections also reach both ends of the step clamp: a step of zero that freezes the counter, and the largest step, which wraps on nearly every clock. A behavioural model compares all four outputs on every cycle, across directed sequences and a long random run.

// File: rtl/pll_pkg.sv
package pll_pkg;
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pll_gain_mul.sv
module pll_gain_mul #(
  parameter int IN_W  = 16,
  parameter int G_W   = 16,
  parameter int FRAC  = 8,
  parameter int OUT_W = 32,
  parameter logic signed [G_W-1:0] GAIN = '0
) (
  input  logic signed [IN_W-1:0]  x_i,
  output logic signed [OUT_W-1:0] y_o
);
  localparam int PW = IN_W + G_W + 1;

  logic signed [PW-1:0] prod, rnd, shf;

  assign prod = PW'(x_i) * PW'(GAIN);
  // round half up, then drop fraction bits
  assign rnd  = prod + (PW'(1) <<< (FRAC - 1));
  assign shf  = rnd >>> FRAC;
  assign y_o  = OUT_W'(shf);
endmodule

// File: rtl/pll_clamp.sv
module pll_clamp #(
  parameter int IN_W  = 20,
  parameter int OUT_W = 16
) (
  input  logic signed [IN_W-1:0]  x_i,
  output logic signed [OUT_W-1:0] y_o,
  output logic                    clip_o
);
  localparam logic signed [IN_W-1:0] MAXV = {{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [IN_W-1:0] MINV = {{(IN_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic hi, lo;

  assign hi     = x_i > MAXV;
  assign lo     = x_i < MINV;
  assign clip_o = hi | lo;

  always_comb begin
    if (hi)      y_o = MAXV[OUT_W-1:0];
    else if (lo) y_o = MINV[OUT_W-1:0];
    else         y_o = x_i[OUT_W-1:0];
  end
endmodule

// File: rtl/pll_sat_acc.sv
module pll_sat_acc #(
  parameter int W    = 16,
  parameter int IN_W = 20
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic signed [IN_W-1:0] add_i,
  output logic signed [W-1:0] acc_nxt_o,
  output logic                sat_o
);
  localparam int SW = IN_W + 1;

  logic signed [W-1:0]  acc_q;
  logic signed [SW-1:0] sum;
  logic                 clip;
  logic                 sat_q;

  assign sum = SW'(acc_q) + SW'(add_i);

  pll_clamp #(.IN_W(SW), .OUT_W(W)) u_clamp (
    .x_i    (sum),
    .y_o    (acc_nxt_o),
    .clip_o (clip)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      sat_q <= 1'b0;
    end else if (en_i) begin
      acc_q <= acc_nxt_o;
      sat_q <= clip;
    end
  end

  assign sat_o = sat_q;
endmodule

// File: rtl/pll_sample_ctr.sv
module pll_sample_ctr #(
  parameter int CNT_W   = 24,
  parameter int FW      = 32,
  parameter int NOM_INC = 1024
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [FW-1:0] freq_i,
  output logic [CNT_W-1:0]     phase_o,
  output logic                 tick_o
);
  localparam int SW = pll_pkg::imax(FW, CNT_W + 1) + 2;
  localparam logic signed [SW-1:0] MAXC = {{(SW-CNT_W){1'b0}}, {CNT_W{1'b1}}};

  logic signed [SW-1:0] step_full;
  logic [CNT_W-1:0]     step;
  logic [CNT_W:0]       sum;
  logic [CNT_W-1:0]     ph_q;
  logic                 tick_q;

  assign step_full = SW'(freq_i) + SW'(NOM_INC);

  // counter never runs backward and never skips a whole period
  always_comb begin
    if (step_full < 0)         step = '0;
    else if (step_full > MAXC) step = MAXC[CNT_W-1:0];
    else                       step = step_full[CNT_W-1:0];
  end

  assign sum = {1'b0, ph_q} + {1'b0, step};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      tick_q <= 1'b0;
    end else begin
      ph_q   <= sum[CNT_W-1:0];
      tick_q <= sum[CNT_W];
    end
  end

  assign phase_o = ph_q;
  assign tick_o  = tick_q;
endmodule

// File: rtl/pll_loop_filter.sv
module pll_loop_filter #(
  parameter int W_PH    = 16,
  parameter int W_FD    = 16,
  parameter int W_ACC   = 32,
  parameter int FRAC    = 16,
  parameter int G_W     = 20,
  parameter logic signed [G_W-1:0] KP = 20'sd2048,
  parameter logic signed [G_W-1:0] KI = 20'sd16,
  parameter logic signed [G_W-1:0] KF = 20'sd256,
  parameter int CNT_W   = 24,
  parameter int NOM_INC = 1048576
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    upd_i,
  input  logic signed [W_PH-1:0]  phase_i,
  input  logic signed [W_PH-1:0]  asym_i,
  input  logic signed [W_FD-1:0]  fdev_i,
  input  logic                    fdev_vld_i,
  output logic signed [W_ACC-1:0] freq_o,
  output logic                    sat_o,
  output logic [CNT_W-1:0]        phase_o,
  output logic                    tick_o
);
  localparam int ERR_W  = W_PH + 1;
  localparam int TERM_W = pll_pkg::imax(ERR_W, W_FD) + G_W - FRAC + 1;
  localparam int SUM_W  = pll_pkg::imax(TERM_W, W_ACC) + 2;

  logic signed [ERR_W-1:0] err;
  logic signed [W_FD-1:0]  fd;
  logic signed [SUM_W-1:0] p_t, i_t, f_t, inc;
  logic signed [W_ACC-1:0] acc_nxt;
  logic signed [SUM_W:0]   fsum;
  logic signed [W_ACC-1:0] fnew;
  logic                    fclip;
  logic signed [W_ACC-1:0] freq_q;

  assign err = ERR_W'(phase_i) - ERR_W'(asym_i);
  assign fd  = fdev_vld_i ? fdev_i : '0;

  pll_gain_mul #(.IN_W(ERR_W), .G_W(G_W), .FRAC(FRAC), .OUT_W(SUM_W), .GAIN(KP)) u_mul_p (
    .x_i (err), .y_o (p_t));
  pll_gain_mul #(.IN_W(ERR_W), .G_W(G_W), .FRAC(FRAC), .OUT_W(SUM_W), .GAIN(KI)) u_mul_i (
    .x_i (err), .y_o (i_t));
  pll_gain_mul #(.IN_W(W_FD), .G_W(G_W), .FRAC(FRAC), .OUT_W(SUM_W), .GAIN(KF)) u_mul_f (
    .x_i (fd), .y_o (f_t));

  // phase integral and frequency feed share one integrator
  assign inc = i_t + f_t;

  pll_sat_acc #(.W(W_ACC), .IN_W(SUM_W)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (upd_i),
    .add_i     (inc),
    .acc_nxt_o (acc_nxt),
    .sat_o     (sat_o)
  );

  assign fsum = (SUM_W+1)'(p_t) + (SUM_W+1)'(acc_nxt);

  pll_clamp #(.IN_W(SUM_W+1), .OUT_W(W_ACC)) u_fclamp (
    .x_i    (fsum),
    .y_o    (fnew),
    .clip_o (fclip)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    freq_q <= '0;
    else if (upd_i) freq_q <= fnew;
  end

  assign freq_o = freq_q;

  pll_sample_ctr #(.CNT_W(CNT_W), .FW(W_ACC), .NOM_INC(NOM_INC)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .freq_i  (freq_q),
    .phase_o (phase_o),
    .tick_o  (tick_o)
  );

  logic unused_ok;
  assign unused_ok = fclip;
endmodule

// File: rtl/pll_loop_filter_chk.sv
module pll_loop_filter_chk #(
  parameter int W_ACC = 32,
  parameter int CNT_W = 24
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    upd_i,
  input logic signed [W_ACC-1:0] freq_o,
  input logic                    sat_o,
  input logic [CNT_W-1:0]        phase_o,
  input logic                    tick_o
);
  assert_hold_freq_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(freq_o));

  assert_hold_sat_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(sat_o));

  assert_sat_on_update_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sat_o) |-> $past(upd_i));

  assert_tick_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (tick_o == (phase_o < $past(phase_o))));

  assert_reset_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (freq_o == '0 && !sat_o && phase_o == '0 && !tick_o));
endmodule

bind pll_loop_filter pll_loop_filter_chk #(.W_ACC(W_ACC), .CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .upd_i   (upd_i),
  .freq_o  (freq_o),
  .sat_o   (sat_o),
  .phase_o (phase_o),
  .tick_o  (tick_o)
);

// File: tb/pll_loop_filter_test.sv
`timescale 1ns/1ps
module pll_loop_filter_test;
  localparam int W_PH = 10, W_FD = 10, W_ACC = 12, FRAC = 4, G_W = 8;
  localparam int KPV = 32, KIV = 8, KFV = 16;
  localparam int CNT_W = 10, NOM_INC = 100;
  localparam longint AMAX = 2047, AMIN = -2048, CMOD = 1024;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic upd_i = 1'b0;
  logic signed [W_PH-1:0] phase_i = '0, asym_i = '0;
  logic signed [W_FD-1:0] fdev_i = '0;
  logic fdev_vld_i = 1'b0;
  logic signed [W_ACC-1:0] freq_o;
  logic sat_o, tick_o;
  logic [CNT_W-1:0] phase_o;

  always #4 clk = ~clk;

  pll_loop_filter #(
    .W_PH(W_PH), .W_FD(W_FD), .W_ACC(W_ACC), .FRAC(FRAC), .G_W(G_W),
    .KP(8'sd32), .KI(8'sd8), .KF(8'sd16), .CNT_W(CNT_W), .NOM_INC(NOM_INC)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni), .upd_i(upd_i), .phase_i(phase_i), .asym_i(asym_i),
    .fdev_i(fdev_i), .fdev_vld_i(fdev_vld_i), .freq_o(freq_o), .sat_o(sat_o),
    .phase_o(phase_o), .tick_o(tick_o)
  );

  int errors = 0, checks = 0;
  bit done = 0;
  longint m_acc = 0, m_freq = 0, m_phase = 0;
  bit m_sat = 0, m_tick = 0;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint rnd(input longint x);
    return (x + (64'sd1 <<< (FRAC - 1))) >>> FRAC;
  endfunction

  function automatic longint clampv(input longint x, input longint lo, input longint hi);
    return (x > hi) ? hi : ((x < lo) ? lo : x);
  endfunction

  task automatic compare_all();
    check("R3 R6 R7 freq", longint'(freq_o), m_freq);
    check("R5 sat", longint'(sat_o), longint'(m_sat));
    check("R8 phase", longint'(phase_o), m_phase);
    check("R9 tick", longint'(tick_o), longint'(m_tick));
  endtask

  // drive at negedge, model the coming edge, compare at next negedge
  task automatic cyc(input bit u, input int ph, input int as, input int fd, input bit v);
    longint e, d, a, st, s;
    upd_i = u; phase_i = W_PH'(ph); asym_i = W_PH'(as);
    fdev_i = W_FD'(fd); fdev_vld_i = v;
    st = clampv(NOM_INC + m_freq, 0, CMOD - 1);
    s = m_phase + st;
    m_tick = (s >= CMOD);
    m_phase = s % CMOD;
    if (u) begin
      e = longint'(ph) - longint'(as);
      d = v ? longint'(fd) : 0;
      a = m_acc + rnd(KIV * e) + rnd(KFV * d);
      m_sat = (a > AMAX) || (a < AMIN);
      m_acc = clampv(a, AMIN, AMAX);
      m_freq = clampv(rnd(KPV * e) + m_acc, AMIN, AMAX);
    end
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    longint held;
    repeat (3) @(negedge clk);
    check("R1 freq", longint'(freq_o), 0);
    check("R1 sat", longint'(sat_o), 0);
    check("R1 phase", longint'(phase_o), 0);
    check("R1 tick", longint'(tick_o), 0);
    rst_ni = 1'b1;
    cyc(0, 0, 0, 0, 0);
    check("R8 first step", longint'(phase_o), 100);
    // R7: +0.5 rounds up, -0.5 rounds to zero
    cyc(1, 1, 0, 0, 0);
    check("R7 R6 err=+1", longint'(freq_o), 3);
    cyc(1, -1, 0, 0, 0);
    check("R7 R6 err=-1", longint'(freq_o), -1);
    // R2: asymmetry cancels the phase input
    cyc(1, 300, 300, 0, 0);
    check("R2 cancel", longint'(freq_o), 1);
    // R4: invalid deviation ignored
    cyc(1, 5, 5, 200, 0);
    check("R4 ignore fdev", longint'(freq_o), 1);
    // R3: valid deviation enters the same accumulator
    cyc(1, 5, 5, 200, 1);
    check("R3 fdev feed", longint'(freq_o), 201);
    // R10: no strobe, inputs toggle
    held = longint'(freq_o);
    cyc(0, 400, -300, 300, 1);
    cyc(0, -400, 100, -300, 1);
    check("R10 hold", longint'(freq_o), held);
    // R5: positive clamp
    repeat (4) cyc(1, 511, -512, 0, 0);
    check("R5 pos clamp freq", longint'(freq_o), 2047);
    check("R5 pos sat flag", longint'(sat_o), 1);
    cyc(1, 0, 0, 0, 0);
    check("R5 flag clears", longint'(sat_o), 0);
    check("R5 acc held at max", longint'(freq_o), 2047);
    // R5: negative clamp, also freezes the counter (R8 step 0)
    repeat (10) cyc(1, -512, 511, -512, 1);
    check("R5 neg clamp freq", longint'(freq_o), -2048);
    check("R5 neg sat flag", longint'(sat_o), 1);
    held = longint'(phase_o);
    cyc(0, 0, 0, 0, 0);
    check("R8 zero step", longint'(phase_o), held);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom_range(0, 3) == 0),
          int'($urandom_range(0, 1023)) - 512, int'($urandom_range(0, 1023)) - 512,
          int'($urandom_range(0, 1023)) - 512, bit'($urandom_range(0, 1)));
    end
    // mid-run reset
    rst_ni = 1'b0;
    m_acc = 0; m_freq = 0; m_phase = 0; m_sat = 0; m_tick = 0;
    @(negedge clk);
    compare_all();
    rst_ni = 1'b1;
    for (int i = 0; i < 200; i++) cyc(1, 200, 0, 100, 1);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule